// File: doc/BRIEF.md
# Masked Table Sequencer

This block steps through a small writable table of 16-bit words. Each rising edge of a step input moves a position pointer forward by one and copies the word found there onto a registered output. The copy goes through an output mask: only output bits whose mask bit is 1 take the new value, and every other output bit keeps the value it had. After the last entry the pointer returns to entry 1, so entry 0 acts only as a start-up word. Entry 0 reaches the output only when the step input is already high in the first clock after reset.

A masked compare port reports, combinationally, whether the entry under the pointer equals a compare word on a chosen set of bits. Comparing never moves the pointer. A load port advances the pointer on the rising edge of its enable and writes its word into the new entry. While the enable stays high, that entry is rewritten on every clock. A host port can preset table entries and the pointer whenever the step input is low.

Top module: `masked_table_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the pointer is 0 and `seq_out` is 0. `match` is 0 whenever `cmp_en` is 0.
- R2: A 0-to-1 transition of `step` advances the pointer by one and loads the entry at the new pointer into `seq_out` at that clock edge. While `step` stays high, there is no further advance and `seq_out` holds.
- R3: An advance from pointer LEN (default 4) goes to pointer 1, never to 0.
- R4: If `step` is high in the first clock after reset is released, the pointer stays at 0 and entry 0 is loaded into `seq_out`. Otherwise the first step loads entry 1.
- R5: On a step, only bits where `out_mask` is 1 take the entry's value. Bits where it is 0 keep their previous value.
- R6: `match` is 1 exactly when `cmp_en` is 1 and the entry at the pointer equals `cmp_word` on every bit where `cmp_mask` is 1.
- R7: Holding `cmp_en` high never changes the pointer.
- R8: A 0-to-1 transition of `ld_en` advances the pointer, wrapping from LEN to 1, and writes `ld_word` into the new entry. While `ld_en` stays high, `ld_word` is written into that same entry on every clock. Loading does not change `seq_out`.
- R9: With `step` low, `wr_en` writes `wr_data` into entry `wr_addr`, and `pos_we` sets the pointer to `pos_val` if `pos_val` is at most LEN. Both are ignored while `step` is high, and a `pos_val` above LEN is ignored.
- R10: If a step edge and `ld_en` coincide, the pointer advances once. `ld_word` is written to the new entry and is also the value sent through the mask to `seq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Step request, acts on its rising edge |
| out_mask | input | 16 | Bits of `seq_out` that a step may update |
| cmp_en | input | 1 | Compare enable |
| cmp_word | input | 16 | Word compared against the current entry |
| cmp_mask | input | 16 | Bits taking part in the compare |
| ld_en | input | 1 | Load enable: advances on its rising edge, writes while high |
| ld_word | input | 16 | Word written by the load port |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | 3 | Host table write index |
| wr_data | input | 16 | Host table write data |
| pos_we | input | 1 | Host pointer preset strobe |
| pos_val | input | 3 | Host pointer preset value |
| seq_out | output | 16 | Masked sequenced output word |
| match | output | 1 | Masked compare result |

## Verification
Two functions can fall in the same clock: a step edge and a load edge. In that case both want to move the pointer, and the step also reads the entry that the load is writing. The bench raises `step` and `ld_en` together on one clock with a fresh load word. It then expects the output to show the load word at once. It also expects the compare port to find that word at the position exactly one past the old one. A further step then confirms, through the wrapped output, that the pointer moved only once.

// File: rtl/masked_table_sequencer.sv
module masked_table_sequencer #(
  parameter int W   = 16,
  parameter int LEN = 4,
  localparam int AW = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [W-1:0]  out_mask,
  input  logic          cmp_en,
  input  logic [W-1:0]  cmp_word,
  input  logic [W-1:0]  cmp_mask,
  input  logic          ld_en,
  input  logic [W-1:0]  ld_word,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          pos_we,
  input  logic [AW-1:0] pos_val,
  output logic [W-1:0]  seq_out,
  output logic          match
);

  logic [W-1:0]  tab [LEN+1];
  logic [AW-1:0] pos, nxt, npos;
  logic          step_q, ld_q, first;
  logic          step_rise, ld_rise, adv, host_ok;
  logic [W-1:0]  src;

  assign step_rise = step & ~step_q;
  assign ld_rise   = ld_en & ~ld_q;
  assign adv       = ld_rise | (step_rise & ~first);
  assign nxt       = (pos == AW'(LEN)) ? AW'(1) : pos + AW'(1);
  assign npos      = adv ? nxt : pos;
  assign src       = ld_en ? ld_word : tab[npos];
  assign host_ok   = ~step;
  assign match     = cmp_en & (((tab[pos] ^ cmp_word) & cmp_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      seq_out <= '0;
      step_q  <= 1'b0;
      ld_q    <= 1'b0;
      first   <= 1'b1;
    end else begin
      step_q <= step;
      ld_q   <= ld_en;
      first  <= 1'b0;
      if (pos_we && host_ok && !ld_rise && int'(pos_val) <= LEN)
        pos <= pos_val;
      else
        pos <= npos;
      if (step_rise)
        seq_out <= (seq_out & ~out_mask) | (src & out_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en)
      tab[npos] <= ld_word;
    else if (wr_en && host_ok && int'(wr_addr) <= LEN)
      tab[wr_addr] <= wr_data;
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_rise |=> $stable(seq_out));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_rise |=> ((seq_out ^ $past(seq_out)) & ~$past(out_mask)) == '0);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && pos == AW'(LEN)) |=> pos == AW'(1));

  // R7
  pos_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_en && !pos_we) |=> $stable(pos));

  // R9
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) <= LEN);

endmodule

// File: tb/sim_masked_table_sequencer.sv
module sim_masked_table_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, step, cmp_en, ld_en, wr_en, pos_we;
  logic [15:0] out_mask, cmp_word, cmp_mask, ld_word, wr_data, seq_out;
  logic [2:0]  wr_addr, pos_val;
  logic        match;
  int          nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_table_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .out_mask(out_mask),
    .cmp_en(cmp_en), .cmp_word(cmp_word), .cmp_mask(cmp_mask),
    .ld_en(ld_en), .ld_word(ld_word), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pos_we(pos_we), .pos_val(pos_val),
    .seq_out(seq_out), .match(match));

  function automatic logic [15:0] ent(int i);
    return 16'h1111 * 16'(i + 1);
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    step = 1'b1; cyc(); step = 1'b0; cyc();
  endtask

  task automatic probe(string tag, logic [15:0] w);
    cmp_en = 1'b1; cmp_mask = 16'hFFFF; cmp_word = w; #1;
    chk(tag, 16'(match), 16'h1);
    cmp_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step = 0; cmp_en = 0; ld_en = 0; wr_en = 0; pos_we = 0;
    out_mask = 16'hFFFF; cmp_word = 0; cmp_mask = 0; ld_word = 0;
    wr_data = 0; wr_addr = 0; pos_val = 0;
    cyc(); cyc();
    chk("R1 out in reset", seq_out, 16'h0);
    chk("R1 match off", 16'(match), 16'h0);
    rst_n = 1'b1; cyc();
    chk("R1 out after reset", seq_out, 16'h0);
  endtask

  task automatic t_host_load();
    for (int i = 0; i < 5; i++) begin
      wr_en = 1'b1; wr_addr = 3'(i); wr_data = ent(i); cyc();
    end
    wr_en = 1'b0;
    probe("R9 host write, pointer 0", ent(0));
  endtask

  task automatic t_step_wrap();
    step = 1'b1; cyc();
    chk("R2 first step", seq_out, ent(1));
    cyc();
    chk("R2 held step", seq_out, ent(1));
    step = 1'b0; cyc();
    for (int i = 2; i < 5; i++) begin
      pulse();
      chk("R2 step sequence", seq_out, ent(i));
    end
    pulse();
    chk("R3 wrap to entry 1", seq_out, ent(1));
  endtask

  task automatic t_mask_cmp();
    out_mask = 16'h000F; pulse();
    chk("R5 masked update", seq_out, 16'h2223);
    out_mask = 16'hFFFF;
    cmp_en = 1'b1; cmp_mask = 16'h0005; cmp_word = 16'h3331; #1;
    chk("R6 masked equal", 16'(match), 16'h1);
    cmp_word = 16'h3337; #1;
    chk("R6 masked differ", 16'(match), 16'h0);
    cmp_en = 1'b0; cmp_word = 16'h3333; #1;
    chk("R6 disabled", 16'(match), 16'h0);
  endtask

  task automatic t_cmp_still();
    cmp_en = 1'b1; cmp_mask = 16'hFFFF; cmp_word = 16'h3333;
    cyc(); cyc(); cyc();
    chk("R7 pointer kept", 16'(match), 16'h1);
    chk("R7 output kept", seq_out, 16'h2223);
    cmp_en = 1'b0;
  endtask

  task automatic t_first_entry();
    rst_n = 1'b0; step = 1'b1; cyc();
    rst_n = 1'b1; cyc();
    chk("R4 entry 0 on first cycle", seq_out, ent(0));
    step = 1'b0; cyc();
    rst_n = 1'b0; cyc();
    rst_n = 1'b1; cyc();
    pulse();
    chk("R4 late step gives entry 1", seq_out, ent(1));
  endtask

  task automatic t_load();
    ld_word = 16'hABCD; ld_en = 1'b1; cyc();
    probe("R8 load edge", 16'hABCD);
    ld_word = 16'h1234; cyc();
    probe("R8 load held rewrites", 16'h1234);
    ld_en = 1'b0; cyc();
    pos_we = 1'b1; pos_val = 3'd4; cyc(); pos_we = 1'b0;
    ld_word = 16'hBEEF; ld_en = 1'b1; cyc(); ld_en = 1'b0; cyc();
    probe("R8 load wraps to 1", 16'hBEEF);
    chk("R8 output untouched", seq_out, ent(1));
  endtask

  task automatic t_host_ignore();
    step = 1'b1; cyc();
    chk("R9 step before ignore", seq_out, 16'h1234);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h0F0F;
    pos_we = 1'b1; pos_val = 3'd0; cyc();
    wr_en = 1'b0; pos_we = 1'b0; step = 1'b0; cyc();
    probe("R9 pointer preset ignored", 16'h1234);
    pulse();
    chk("R9 table write ignored", seq_out, ent(3));
    pos_we = 1'b1; pos_val = 3'd7; cyc(); pos_we = 1'b0;
    probe("R9 out of range preset", ent(3));
  endtask

  task automatic t_coincide();
    step = 1'b1; ld_en = 1'b1; ld_word = 16'hC0DE; cyc();
    chk("R10 output takes load word", seq_out, 16'hC0DE);
    step = 1'b0; ld_en = 1'b0; cyc();
    probe("R10 single advance", 16'hC0DE);
    pulse();
    chk("R10 next step wraps", seq_out, 16'hBEEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_host_load();
    t_step_wrap();
    t_mask_cmp();
    t_cmp_still();
    t_first_entry();
    t_load();
    t_host_ignore();
    t_coincide();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule